// File: doc/BRIEF.md
# Slave-mode 4:2:2 input aligner

This block takes an 8-bit multiplexed 4:2:2 byte stream on the 27 MHz video clock. Horizontal and vertical sync come from an external source. The rising edge of the horizontal sync marks position 1 of a line. A free-running position counter wraps at the line length of the selected standard: 1716 clocks for the 525-line standard and 1728 for the 625-line standard. A fixed offset from position 1 opens a window of 1440 active bytes. Inside that window the bytes are split into chroma and luma and delivered as pixel pairs (Cb, Y0, Cr, Y1). Each pair comes with a one-cycle valid strobe, the index of its first pixel and the current line number.

A sync-delay input moves the whole active window one clock later. A vertical sync rising edge clears the line number. An early horizontal sync forces the counter back to position 1 and sets a sticky length-error flag. While the master-mode input is high the block does nothing: it drops its horizontal lock and holds the line number.

Top module: `vid_slave_aligner`

## Requirements
- R1: After reset, every output is 0. Until the first rising edge of `hsync_i` has been seen, the block emits no pair.
- R2: The clock in which `hsync_i` is first sampled high is position 1. With no further sync, the position runs to 1716 (`pal_sel_i`=0) or 1728 (`pal_sel_i`=1) and then wraps to 1. The active window repeats on every wrapped line.
- R3: With `sync_dly_i`=0, the byte at position 245 (`pal_sel_i`=0) or 265 (`pal_sel_i`=1) is the first active byte, carrying Cb of pixel pair 0.
- R4: With `sync_dly_i`=1, the first active byte is at position 246 or 266, and the whole window moves by one clock.
- R5: Active bytes with offsets 4m, 4m+1, 4m+2 and 4m+3 from the first active byte are Cb, Y0, Cr and Y1 of pair m. In the cycle after the Y1 byte is sampled, `pair_valid_o` is 1 for one cycle and the four bytes appear on `cb_o`, `y0_o`, `cr_o` and `y1_o`.
- R6: The window covers 1440 bytes, so a line gives 360 pairs with `pix_idx_o` = 2m (0 to 718). `pair_valid_o` is never high for any other position.
- R7: A rising edge of `vsync_i` sets `line_idx_o` to 0 in the next cycle. Otherwise each rising edge of `hsync_i` adds 1. A vertical edge takes priority over a horizontal edge in the same cycle.
- R8: A rising edge of `hsync_i` while locked, when the previous position is not the line length, restarts the line at position 1 at once. It also sets `len_err_o`, which stays set until reset.
- R9: While `master_en_i` is 1, no pair is emitted, horizontal lock is dropped and `line_idx_o` holds its value. After `master_en_i` returns to 0, pairs resume only after a new `hsync_i` rising edge.
- R10: `line_idx_o` saturates at its all-ones value (1023 by default) under further horizontal edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 27 MHz video clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| master_en_i | input | 1 | Master-mode select; the aligner is idle while high |
| pal_sel_i | input | 1 | 0: 1716-clock lines, 1: 1728-clock lines |
| sync_dly_i | input | 1 | Moves the active window one clock later |
| hsync_i | input | 1 | Horizontal sync, active high, rising edge used |
| vsync_i | input | 1 | Vertical sync, active high, rising edge used |
| data_i | input | DATA_W (8) | Multiplexed 4:2:2 byte |
| pair_valid_o | output | 1 | One-cycle strobe for a new pixel pair |
| cb_o | output | DATA_W (8) | Blue-difference chroma of the pair |
| y0_o | output | DATA_W (8) | Luma of the first pixel |
| cr_o | output | DATA_W (8) | Red-difference chroma of the pair |
| y1_o | output | DATA_W (8) | Luma of the second pixel |
| pix_idx_o | output | PIX_W (10) | Index of the first pixel of the pair |
| line_idx_o | output | LINE_W (10) | Line number since the last vertical edge |
| len_err_o | output | 1 | Sticky early-sync flag |

## Verification
The bench targets the window edges under both standards and both delay settings. A one-clock error in the window start would shift every chroma and luma byte into the wrong slot, so each pair's contents would miscompare. It runs a line that wraps with no sync pulse, to catch a counter that stops or wraps one clock off. It sends an early horizontal sync, which must restart the line and set the sticky flag, while on-time syncs must leave the flag clear. It also drives a vertical edge in the same cycle as a horizontal edge, sync pulses during master mode, and a long run of short lines that pushes the line number into saturation. A wrong priority, a line counter that keeps counting during master mode, or a counter that wraps past its top value would each show up as a wrong line number.

// File: rtl/vsa_pkg.sv
`timescale 1ns/1ps
package vsa_pkg;

   // Byte slot inside a four-byte group of the active window
   typedef enum logic [1:0] {
      PH_CB = 2'd0,
      PH_Y0 = 2'd1,
      PH_CR = 2'd2,
      PH_Y1 = 2'd3
   } vsa_phase_e;

endpackage

// File: rtl/vsa_edge.sv
`timescale 1ns/1ps
module vsa_edge (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic d_i,
   output logic rise_o
);
   logic d_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) d_q <= 1'b0;
      else         d_q <= d_i;
   end

   assign rise_o = d_i & ~d_q;
endmodule

// File: rtl/vsa_hcount.sv
`timescale 1ns/1ps
module vsa_hcount #(
   parameter int NTSC_LEN = 1716,
   parameter int PAL_LEN  = 1728,
   parameter int HCNT_W   = 11
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              idle_i,
   input  logic              pal_i,
   input  logic              hs_rise_i,
   output logic [HCNT_W-1:0] hpos_o,
   output logic              len_err_o
);
   localparam logic [HCNT_W-1:0] LEN_A = HCNT_W'(NTSC_LEN);
   localparam logic [HCNT_W-1:0] LEN_B = HCNT_W'(PAL_LEN);

   logic [HCNT_W-1:0] hcnt_q;
   logic [HCNT_W-1:0] line_len;
   logic              early;
   logic              err_q;

   assign line_len = pal_i ? LEN_B : LEN_A;

   // Position of the byte sampled at this edge; 0 means not locked
   always_comb begin
      if (idle_i)                 hpos_o = '0;
      else if (hs_rise_i)         hpos_o = HCNT_W'(1);
      else if (hcnt_q == '0)      hpos_o = '0;
      else if (hcnt_q >= line_len) hpos_o = HCNT_W'(1);
      else                        hpos_o = hcnt_q + HCNT_W'(1);
   end

   assign early = hs_rise_i & ~idle_i & (hcnt_q != '0) & (hcnt_q != line_len);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hcnt_q <= '0;
         err_q  <= 1'b0;
      end else begin
         hcnt_q <= hpos_o;
         if (early) err_q <= 1'b1;
      end
   end

   assign len_err_o = err_q;
endmodule

// File: rtl/vsa_window.sv
`timescale 1ns/1ps
module vsa_window
   import vsa_pkg::*;
#(
   parameter int NTSC_FIRST = 245,
   parameter int PAL_FIRST  = 265,
   parameter int ACT_BYTES  = 1440,
   parameter int HCNT_W     = 11,
   parameter int OFS_W      = 11
) (
   input  logic [HCNT_W-1:0] hpos_i,
   input  logic              pal_i,
   input  logic              dly_i,
   output logic              in_win_o,
   output vsa_phase_e        phase_o,
   output logic [OFS_W-1:0]  ofs_o
);
   localparam int SW = HCNT_W + 1;

   logic [SW-1:0] first;
   logic [SW-1:0] end_ex;
   logic [SW-1:0] pos;

   assign pos      = {1'b0, hpos_i};
   assign first    = SW'(pal_i ? PAL_FIRST : NTSC_FIRST) + SW'(dly_i);
   assign end_ex   = first + SW'(ACT_BYTES);
   assign in_win_o = (hpos_i != '0) && (pos >= first) && (pos < end_ex);
   assign ofs_o    = OFS_W'(pos - first);
   assign phase_o  = vsa_phase_e'(ofs_o[1:0]);
endmodule

// File: rtl/vsa_demux.sv
`timescale 1ns/1ps
module vsa_demux
   import vsa_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int OFS_W  = 11,
   parameter int PIX_W  = 10
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              in_win_i,
   input  vsa_phase_e        phase_i,
   input  logic [OFS_W-1:0]  ofs_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              pair_valid_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] y0_o,
   output logic [DATA_W-1:0] cr_o,
   output logic [DATA_W-1:0] y1_o,
   output logic [PIX_W-1:0]  pix_idx_o
);
   logic last_slot;
   assign last_slot = in_win_i && (phase_i == PH_Y1);

   // One holding register for each of the first three bytes of a group
   for (genvar g = 0; g < 3; g++) begin : g_cap
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)                                     q <= '0;
         else if (in_win_i && phase_i == vsa_phase_e'(g)) q <= data_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         pair_valid_o <= 1'b0;
         cb_o         <= '0;
         y0_o         <= '0;
         cr_o         <= '0;
         y1_o         <= '0;
         pix_idx_o    <= '0;
      end else begin
         pair_valid_o <= last_slot;
         if (last_slot) begin
            cb_o      <= g_cap[0].q;
            y0_o      <= g_cap[1].q;
            cr_o      <= g_cap[2].q;
            y1_o      <= data_i;
            pix_idx_o <= {ofs_i[OFS_W-1:2], 1'b0};
         end
      end
   end
endmodule

// File: rtl/vsa_vcount.sv
`timescale 1ns/1ps
module vsa_vcount #(
   parameter int LINE_W   = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              idle_i,
   input  logic              hs_rise_i,
   input  logic              vs_rise_i,
   output logic [LINE_W-1:0] line_o
);
   logic [LINE_W-1:0] line_q;
   logic [LINE_W-1:0] step;

   if (SATURATE) begin : g_sat
      assign step = (line_q == '1) ? line_q : line_q + LINE_W'(1);
   end else begin : g_wrap
      assign step = line_q + LINE_W'(1);
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         line_q <= '0;
      else if (!idle_i) begin
         if (vs_rise_i)      line_q <= '0;
         else if (hs_rise_i) line_q <= step;
      end
   end

   assign line_o = line_q;
endmodule

// File: rtl/vid_slave_aligner.sv
`timescale 1ns/1ps
module vid_slave_aligner
   import vsa_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int NTSC_LEN   = 1716,
   parameter int PAL_LEN    = 1728,
   parameter int NTSC_FIRST = 245,
   parameter int PAL_FIRST  = 265,
   parameter int ACT_BYTES  = 1440,
   parameter int LINE_W     = 10,
   parameter bit LINE_SAT   = 1'b1,
   localparam int OFS_W     = $clog2(ACT_BYTES),
   localparam int PIX_W     = OFS_W - 1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              master_en_i,
   input  logic              pal_sel_i,
   input  logic              sync_dly_i,
   input  logic              hsync_i,
   input  logic              vsync_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              pair_valid_o,
   output logic [DATA_W-1:0] cb_o,
   output logic [DATA_W-1:0] y0_o,
   output logic [DATA_W-1:0] cr_o,
   output logic [DATA_W-1:0] y1_o,
   output logic [PIX_W-1:0]  pix_idx_o,
   output logic [LINE_W-1:0] line_idx_o,
   output logic              len_err_o
);
   localparam int MAX_LEN = (NTSC_LEN > PAL_LEN) ? NTSC_LEN : PAL_LEN;
   localparam int HCNT_W  = $clog2(MAX_LEN + 1);

   // Elaboration-time parameter checks
   if (ACT_BYTES % 4 != 0) begin : g_bad_act
      $error("ACT_BYTES must be a multiple of four");
   end
   if (NTSC_FIRST < 1 || NTSC_FIRST + ACT_BYTES > NTSC_LEN) begin : g_bad_ntsc
      $error("window does not fit the short line");
   end
   if (PAL_FIRST < 1 || PAL_FIRST + ACT_BYTES > PAL_LEN) begin : g_bad_pal
      $error("window does not fit the long line");
   end
   if (DATA_W < 1 || LINE_W < 1) begin : g_bad_w
      $error("widths must be positive");
   end

   logic [1:0] sync_in;
   logic [1:0] sync_rise;
   assign sync_in = {vsync_i, hsync_i};

   for (genvar s = 0; s < 2; s++) begin : g_edge
      vsa_edge u_edge (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .d_i    (sync_in[s]),
         .rise_o (sync_rise[s])
      );
   end

   logic [HCNT_W-1:0] hpos;
   logic              in_win;
   vsa_phase_e        phase;
   logic [OFS_W-1:0]  ofs;

   vsa_hcount #(
      .NTSC_LEN (NTSC_LEN),
      .PAL_LEN  (PAL_LEN),
      .HCNT_W   (HCNT_W)
   ) u_hcount (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idle_i    (master_en_i),
      .pal_i     (pal_sel_i),
      .hs_rise_i (sync_rise[0]),
      .hpos_o    (hpos),
      .len_err_o (len_err_o)
   );

   vsa_window #(
      .NTSC_FIRST (NTSC_FIRST),
      .PAL_FIRST  (PAL_FIRST),
      .ACT_BYTES  (ACT_BYTES),
      .HCNT_W     (HCNT_W),
      .OFS_W      (OFS_W)
   ) u_window (
      .hpos_i   (hpos),
      .pal_i    (pal_sel_i),
      .dly_i    (sync_dly_i),
      .in_win_o (in_win),
      .phase_o  (phase),
      .ofs_o    (ofs)
   );

   vsa_demux #(
      .DATA_W (DATA_W),
      .OFS_W  (OFS_W),
      .PIX_W  (PIX_W)
   ) u_demux (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .in_win_i     (in_win),
      .phase_i      (phase),
      .ofs_i        (ofs),
      .data_i       (data_i),
      .pair_valid_o (pair_valid_o),
      .cb_o         (cb_o),
      .y0_o         (y0_o),
      .cr_o         (cr_o),
      .y1_o         (y1_o),
      .pix_idx_o    (pix_idx_o)
   );

   vsa_vcount #(
      .LINE_W   (LINE_W),
      .SATURATE (LINE_SAT)
   ) u_vcount (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .idle_i    (master_en_i),
      .hs_rise_i (sync_rise[0]),
      .vs_rise_i (sync_rise[1]),
      .line_o    (line_idx_o)
   );
endmodule

// File: rtl/vsa_checker.sv
`timescale 1ns/1ps
module vsa_checker #(
   parameter int LINE_W    = 10,
   parameter int PIX_W     = 10,
   parameter int ACT_BYTES = 1440
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              master_en_i,
   input logic              hsync_i,
   input logic              vsync_i,
   input logic              pair_valid_o,
   input logic [PIX_W-1:0]  pix_idx_o,
   input logic [LINE_W-1:0] line_idx_o,
   input logic              len_err_o
);
   localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(ACT_BYTES / 2 - 2);

   assert_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      master_en_i |=> !pair_valid_o);

   assert_err_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      len_err_o |=> len_err_o);

   assert_vs_clear_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(vsync_i) && !master_en_i) |=> (line_idx_o == '0));

   assert_line_step_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($rose(hsync_i) && !$rose(vsync_i) && !master_en_i && line_idx_o != '1)
      |=> (line_idx_o == $past(line_idx_o) + LINE_W'(1)));

   assert_line_sat_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (line_idx_o == '1 && !$rose(vsync_i)) |=> (line_idx_o == '1));

   assert_pair_gap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_valid_o |=> !pair_valid_o);

   assert_pix_range_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pair_valid_o |-> (pix_idx_o[0] == 1'b0 && pix_idx_o <= LAST_PIX));
endmodule

bind vid_slave_aligner vsa_checker #(
   .LINE_W    (LINE_W),
   .PIX_W     (PIX_W),
   .ACT_BYTES (ACT_BYTES)
) u_vsa_checker (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .master_en_i  (master_en_i),
   .hsync_i      (hsync_i),
   .vsync_i      (vsync_i),
   .pair_valid_o (pair_valid_o),
   .pix_idx_o    (pix_idx_o),
   .line_idx_o   (line_idx_o),
   .len_err_o    (len_err_o)
);

// File: tb/vid_slave_aligner_tb_top.sv
`timescale 1ns/1ps
module vid_slave_aligner_tb_top;
   localparam int NL = 1716;
   localparam int PL = 1728;
   localparam int NF = 245;
   localparam int PF = 265;
   localparam int AB = 1440;
   localparam int LMAX = 1023;

   logic       clk = 1'b0;
   logic       rst_ni = 1'b0;
   logic       master_en_i = 1'b0;
   logic       pal_sel_i = 1'b0;
   logic       sync_dly_i = 1'b0;
   logic       hsync_i = 1'b0;
   logic       vsync_i = 1'b0;
   logic [7:0] data_i = '0;
   logic       pair_valid_o;
   logic [7:0] cb_o, y0_o, cr_o, y1_o;
   logic [9:0] pix_idx_o;
   logic [9:0] line_idx_o;
   logic       len_err_o;

   always #2.5 clk = ~clk;

   vid_slave_aligner dut_i (
      .clk_i        (clk),
      .rst_ni       (rst_ni),
      .master_en_i  (master_en_i),
      .pal_sel_i    (pal_sel_i),
      .sync_dly_i   (sync_dly_i),
      .hsync_i      (hsync_i),
      .vsync_i      (vsync_i),
      .data_i       (data_i),
      .pair_valid_o (pair_valid_o),
      .cb_o         (cb_o),
      .y0_o         (y0_o),
      .cr_o         (cr_o),
      .y1_o         (y1_o),
      .pix_idx_o    (pix_idx_o),
      .line_idx_o   (line_idx_o),
      .len_err_o    (len_err_o)
   );

   int total = 0;
   int bad = 0;
   string cur_req = "R1";

   // Reference state derived from the requirements
   int  m_p = 0;
   int  m_line = 0;
   bit  m_err = 0;
   bit  hs_prev = 0;
   bit  vs_prev = 0;
   logic [7:0] bytes [0:2047];

   task automatic chk_eq(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s act=%0d exp=%0d", req, what, act, exp);
      end
   endtask

   function automatic int line_len(bit pal);
      return pal ? PL : NL;
   endfunction

   function automatic int first_pos(bit pal, bit dly);
      return (pal ? PF : NF) + int'(dly);
   endfunction

   task automatic cyc(bit hs, bit vs, bit m);
      bit rh, rv, expv;
      int len, first, k;
      logic [7:0] d;
      d = 8'($urandom);
      hsync_i = hs; vsync_i = vs; master_en_i = m; data_i = d;
      len = line_len(pal_sel_i);
      first = first_pos(pal_sel_i, sync_dly_i);
      rh = hs && !hs_prev;
      rv = vs && !vs_prev;
      hs_prev = hs; vs_prev = vs;
      if (m) m_p = 0;
      else begin
         if (rh) begin
            if (m_p != 0 && m_p != len) m_err = 1;
            m_p = 1;
         end else if (m_p != 0) m_p = (m_p == len) ? 1 : m_p + 1;
         if (rv) m_line = 0;
         else if (rh && m_line != LMAX) m_line++;
      end
      expv = 0;
      k = 0;
      if (!m && m_p != 0) begin
         bytes[m_p] = d;
         k = m_p - first;
         if (k >= 0 && k < AB && (k % 4) == 3) expv = 1;
      end
      @(posedge clk);
      #1;
      chk_eq(cur_req, "pair_valid", int'(pair_valid_o), int'(expv));
      if (expv) begin
         chk_eq("R5", "cb", int'(cb_o), int'(bytes[m_p-3]));
         chk_eq("R5", "y0", int'(y0_o), int'(bytes[m_p-2]));
         chk_eq("R5", "cr", int'(cr_o), int'(bytes[m_p-1]));
         chk_eq("R5", "y1", int'(y1_o), int'(d));
         chk_eq("R6", "pix_idx", int'(pix_idx_o), (k - 3) / 2);
      end
      chk_eq("R7", "line_idx", int'(line_idx_o), m_line);
      chk_eq("R8", "len_err", int'(len_err_o), int'(m_err));
   endtask

   task automatic run_line(int n, int hw, int vs_at);
      for (int i = 0; i < n; i++)
         cyc(i < hw, (vs_at >= 0) && (i >= vs_at) && (i < vs_at + 3), 1'b0);
   endtask

   task automatic set_std(bit pal, bit dly);
      for (int i = 0; i < 3; i++) cyc(1'b0, 1'b0, 1'b1);
      pal_sel_i = pal;
      sync_dly_i = dly;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog act=150000 cycles exp=fewer");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd5150));
      repeat (4) @(posedge clk);
      #1;
      // R1: reset values
      chk_eq("R1", "reset pair_valid", int'(pair_valid_o), 0);
      chk_eq("R1", "reset cb", int'(cb_o), 0);
      chk_eq("R1", "reset y1", int'(y1_o), 0);
      chk_eq("R1", "reset pix", int'(pix_idx_o), 0);
      chk_eq("R1", "reset line", int'(line_idx_o), 0);
      chk_eq("R1", "reset err", int'(len_err_o), 0);
      rst_ni = 1'b1;

      // R1: no lock yet, no pairs
      cur_req = "R1";
      run_line(400, 0, -1);

      // R3: short lines, no delay
      set_std(1'b0, 1'b0);
      cur_req = "R3";
      run_line(NL, 1 + int'($urandom % 100), -1);
      run_line(NL, 1 + int'($urandom % 100), -1);
      cur_req = "R2";
      run_line(NL, 0, -1);
      cur_req = "R3";
      run_line(NL, 1 + int'($urandom % 100), -1);

      // R4: short lines, delayed
      set_std(1'b0, 1'b1);
      cur_req = "R4";
      run_line(NL, 1 + int'($urandom % 100), -1);
      run_line(NL, 1 + int'($urandom % 100), -1);

      // R3 / R2: long lines
      set_std(1'b1, 1'b0);
      cur_req = "R3";
      run_line(PL, 1 + int'($urandom % 100), -1);
      cur_req = "R2";
      run_line(PL, 0, -1);
      cur_req = "R3";
      run_line(PL, 1 + int'($urandom % 100), -1);

      // R4: long lines, delayed
      set_std(1'b1, 1'b1);
      cur_req = "R4";
      run_line(PL, 1 + int'($urandom % 100), -1);
      run_line(PL, 1 + int'($urandom % 100), -1);

      // R7: vertical edge mid-line, then coincident with horizontal edge
      cur_req = "R7";
      run_line(PL, 20, 100);
      run_line(PL, 20, 0);
      run_line(PL, 20, -1);

      // R8: early horizontal sync
      cur_req = "R8";
      run_line(900, 10, -1);
      run_line(PL, 10, -1);
      run_line(PL, 10, -1);

      // R9: master mode with sync pulses, then unlocked until a new edge
      cur_req = "R9";
      for (int i = 0; i < 400; i++) cyc((i % 50) < 5, 1'b0, 1'b1);
      run_line(2000, 0, -1);
      run_line(PL, 8, -1);

      // R10: many short lines drive the line number to saturation
      cur_req = "R10";
      for (int i = 0; i < 1100; i++) begin
         cyc(1'b1, 1'b0, 1'b0);
         cyc(1'b0, 1'b0, 1'b0);
      end
      cyc(1'b0, 1'b1, 1'b0);
      cyc(1'b0, 1'b0, 1'b0);

      // Random mix of standard, delay, pulse width and vertical edge
      for (int r = 0; r < 4; r++) begin
         bit pal, dly;
         int vs_at;
         pal = 1'($urandom);
         dly = 1'($urandom);
         set_std(pal, dly);
         cur_req = dly ? "R4" : "R3";
         vs_at = (($urandom % 3) == 0) ? int'($urandom % 1500) : -1;
         run_line(line_len(pal), 1 + int'($urandom % 200), -1);
         run_line(line_len(pal), 1 + int'($urandom % 200), vs_at);
      end

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule